// File: doc/BRIEF.md
# Self-Configuring Peripheral Bus Front End

This block is the slave-side entry point of a two-channel serial controller that also contains a DMA cell. It does not have a fixed bus style. After a hardware reset it waits for the host's first write, which must select the DMA cell. That write goes to a hidden configuration register instead of any addressed register. If an address strobe was seen at any time since reset, including during that write, the block locks into multiplexed decoding. Otherwise it locks into non-multiplexed decoding. The channel-select input sampled during the configuration write sets the role of the handshake pin. Data bit 0 of that write sets the address shift used by the DMA cell.

Once configured, each host access produces a one-cycle read or write strobe toward a register-file stub. The strobe comes with a cell flag, a channel flag, a 5-bit register index and the write byte. In multiplexed mode the index is cut from the address latched by the strobe, shifted left or right. In non-multiplexed mode the serial cell is reached through a pointer held in its register 0, and the DMA cell through a pointer held in its command register. A pointer falls back to zero after the access it redirected. Read data is placed on both byte lanes of the 16-bit bus.

Top module: `pbus_front`

The control FSM has five states:

| State | Meaning |
|---|---|
| ST_UNCONF | Waiting for the configuration write |
| ST_CFGW | Configuration write in progress |
| ST_IDLE | Ready for an access |
| ST_WRITE | Write in progress |
| ST_READ | Read in progress |

Its transitions are:
- ST_UNCONF goes to ST_CFGW when a write starts with cell select low.
- ST_CFGW goes to ST_IDLE when the access ends.
- ST_IDLE goes to ST_WRITE when a write starts, or to ST_READ when a read starts.
- ST_WRITE and ST_READ go to ST_IDLE when the access ends.

An access is active while `cs_n` is low and `rd_n` or `wr_n` is low. It starts in the first cycle it is active.

## Requirements
- R1: While unconfigured, a read, or a write with `sel_serial` high, is ignored. It raises no strobe, does not drive `ad_oe`, and leaves `cfg_done` at 0.
- R2: The first write with `sel_serial` low raises no register strobe. It sets `cfg_done` once the access ends.
- R3: `cfg_mux` becomes 1 if `as_n` was low in any cycle after reset up to the end of the configuration write, even with `cs_n` high. Otherwise it becomes 0.
- R4: `cfg_wait_role` takes the value of `sel_chan_a` at the start of the configuration write (1 = active-low wait, 0 = active-low ready).
- R5: Bit 0 of the configuration write data sets the DMA cell's shift: 1 = left (index from address bits 5..1), 0 = right (index from address bits 4..0).
- R6: In multiplexed mode, a serial write that resolves to index 0 updates the serial shift from data bits 1:0: 01 selects left, 10 selects right, and 00 or 11 keeps it. After reset the serial shift is right.
- R7: In non-multiplexed mode with the serial pointer at 0, a serial access goes to index 0. A write there loads the pointer from data bits 3:0. The next serial access goes to that index and clears the pointer.
- R8: When the DMA base index is 0 (always in non-multiplexed mode, or from the address in multiplexed mode), a zero DMA pointer selects index 0. A write there loads the pointer from data bits 4:0. A nonzero pointer redirects that access and is then cleared. A nonzero base index ignores the pointer.
- R9: In multiplexed mode, serial writes never load a pointer. Serial accesses always use the latched address.
- R10: `reg_cell_dma` is 1 for the DMA cell (`sel_serial` low) and 0 for the serial cell. `reg_chan_a` equals `sel_chan_a` for serial accesses and 0 for DMA accesses.
- R11: While a read is active, `ad_oe` is 1 and both bytes of `ad_out` equal `reg_rd_data`.
- R12: A write raises `reg_wr_stb` for exactly one cycle, the cycle after it starts, with `reg_wdata` = `ad_in[7:0]`.
- R13: Reset returns the block to the unconfigured state. After configuration, the configuration is fixed, and a later write with `sel_serial` low is an ordinary DMA-cell write.
- R14: A read raises `reg_rd_stb` for exactly one cycle, the cycle after it starts. The index is held until the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| cs_n | input | 1 | Chip enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel_serial | input | 1 | Cell select: 1 = serial cell, 0 = DMA cell |
| sel_chan_a | input | 1 | Serial channel select: 1 = A, 0 = B |
| ad_in | input | 16 | Address/data bus, inbound |
| ad_out | output | 16 | Address/data bus, outbound |
| ad_oe | output | 1 | Output enable for `ad_out` |
| reg_rd_data | input | 8 | Read byte from the register stub |
| reg_wr_stb | output | 1 | Register write strobe |
| reg_rd_stb | output | 1 | Register read strobe |
| reg_cell_dma | output | 1 | Target cell: 1 = DMA cell |
| reg_chan_a | output | 1 | Target serial channel A |
| reg_idx | output | 5 | Target register index |
| reg_wdata | output | 8 | Write byte |
| cfg_done | output | 1 | Configuration write completed |
| cfg_mux | output | 1 | Multiplexed decoding selected |
| cfg_wait_role | output | 1 | Handshake pin acts as wait (1) or ready (0) |

## Verification
The address strobe can arrive in the same cycle that the configuration write starts. In that case strobe tracking and the configuration capture act on the same clock edge. The bench provokes this by dropping `as_n` in the very cycle the first write begins, with no earlier strobe. It then judges the result by `cfg_mux` being 1 after the write and by a shifted multiplexed index on the next access. A second case has a DMA pointer clear and a new pointer load fall on consecutive accesses. The bench checks that the redirected access does not reload the pointer.

// File: rtl/pbus_front_pkg.sv
package pbus_front_pkg;

    typedef enum logic [2:0] {
        ST_UNCONF = 3'd0,
        ST_CFGW   = 3'd1,
        ST_IDLE   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_READ   = 3'd4
    } pbus_state_e;

    // serial shift command field in data bits 1:0
    localparam logic [1:0] SHIFT_CMD_LEFT  = 2'b01;
    localparam logic [1:0] SHIFT_CMD_RIGHT = 2'b10;

endpackage

// File: rtl/pbus_addr_latch.sv
module pbus_addr_latch #(
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             track_en,
    input  logic [LAT_W-1:0] ad_low,
    output logic [LAT_W-1:0] addr_q,
    output logic             as_seen
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (!as_n) begin
            addr_q <= ad_low;
        end
    end

    // remembers any strobe since reset until the bus style is fixed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_seen <= 1'b0;
        end else if (track_en && !as_n) begin
            as_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/pbus_index_decode.sv
module pbus_index_decode #(
    parameter int IDX_W  = 5,
    parameter int SPTR_W = 4
) (
    input  logic              mux_mode,
    input  logic              sel_serial,
    input  logic [IDX_W:0]    addr_q,
    input  logic              ser_shl,
    input  logic              dma_shl,
    input  logic [SPTR_W-1:0] ser_ptr,
    input  logic [IDX_W-1:0]  dma_ptr,
    output logic [IDX_W-1:0]  idx,
    output logic              ptr_hit,
    output logic              idx_zero
);

    localparam int PAD_W = IDX_W - SPTR_W;

    logic [IDX_W-1:0] ser_base;
    logic [IDX_W-1:0] dma_base;
    logic             ser_hit;
    logic             dma_hit;

    always_comb begin
        ser_base = '0;
        dma_base = '0;
        if (mux_mode) begin
            ser_base = ser_shl ? addr_q[IDX_W:1] : addr_q[IDX_W-1:0];
            dma_base = dma_shl ? addr_q[IDX_W:1] : addr_q[IDX_W-1:0];
        end
    end

    assign ser_hit = !mux_mode && (ser_ptr != '0);
    assign dma_hit = (dma_base == '0) && (dma_ptr != '0);

    always_comb begin
        if (sel_serial) begin
            idx     = ser_hit ? {{PAD_W{1'b0}}, ser_ptr} : ser_base;
            ptr_hit = ser_hit;
        end else begin
            idx     = dma_hit ? dma_ptr : dma_base;
            ptr_hit = dma_hit;
        end
        idx_zero = (idx == '0);
    end

endmodule

// File: rtl/pbus_pointer_regs.sv
module pbus_pointer_regs
    import pbus_front_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int SPTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              is_wr,
    input  logic              sel_serial,
    input  logic              mux_mode,
    input  logic              ptr_hit,
    input  logic              idx_zero,
    input  logic [IDX_W-1:0]  wdata,
    output logic [SPTR_W-1:0] ser_ptr,
    output logic [IDX_W-1:0]  dma_ptr,
    output logic              ser_shl
);

    logic load_zero;
    assign load_zero = acc_start && is_wr && idx_zero && !ptr_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_ptr <= '0;
            ser_shl <= 1'b0;
        end else if (acc_start && sel_serial) begin
            if (ptr_hit) begin
                ser_ptr <= '0;
            end else if (load_zero) begin
                if (mux_mode) begin
                    if (wdata[1:0] == SHIFT_CMD_LEFT) begin
                        ser_shl <= 1'b1;
                    end else if (wdata[1:0] == SHIFT_CMD_RIGHT) begin
                        ser_shl <= 1'b0;
                    end
                end else begin
                    ser_ptr <= wdata[SPTR_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_ptr <= '0;
        end else if (acc_start && !sel_serial) begin
            if (ptr_hit) begin
                dma_ptr <= '0;
            end else if (load_zero) begin
                dma_ptr <= wdata;
            end
        end
    end

endmodule

// File: rtl/pbus_front.sv
module pbus_front
    import pbus_front_pkg::*;
#(
    parameter int AD_W   = 16,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5,
    parameter int SPTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              sel_serial,
    input  logic              sel_chan_a,
    input  logic [AD_W-1:0]   ad_in,
    output logic [AD_W-1:0]   ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_stb,
    output logic              reg_rd_stb,
    output logic              reg_cell_dma,
    output logic              reg_chan_a,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              cfg_done,
    output logic              cfg_mux,
    output logic              cfg_wait_role
);

    localparam int LANES = AD_W / DATA_W;
    localparam int LAT_W = IDX_W + 1;

    pbus_state_e state, nxt;

    logic              act, act_q, start, is_wr;
    logic              acc_start;
    logic [LAT_W-1:0]  addr_q;
    logic              as_seen;
    logic              dma_shl, ser_shl;
    logic [SPTR_W-1:0] ser_ptr;
    logic [IDX_W-1:0]  dma_ptr;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_hit, dec_zero;
    logic              track_en;
    logic [AD_W-DATA_W-1:0] unused_ad_hi;

    assign unused_ad_hi = ad_in[AD_W-1:DATA_W];

    assign act   = !cs_n && (!rd_n || !wr_n);
    assign start = act && !act_q;
    assign is_wr = !wr_n;
    assign acc_start = (state == ST_IDLE) && start;
    assign track_en  = (state == ST_UNCONF) || (state == ST_CFGW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act;
        end
    end

    pbus_addr_latch #(.LAT_W(LAT_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_n     (as_n),
        .track_en (track_en),
        .ad_low   (ad_in[LAT_W-1:0]),
        .addr_q   (addr_q),
        .as_seen  (as_seen)
    );

    pbus_index_decode #(.IDX_W(IDX_W), .SPTR_W(SPTR_W)) u_dec (
        .mux_mode   (cfg_mux),
        .sel_serial (sel_serial),
        .addr_q     (addr_q),
        .ser_shl    (ser_shl),
        .dma_shl    (dma_shl),
        .ser_ptr    (ser_ptr),
        .dma_ptr    (dma_ptr),
        .idx        (dec_idx),
        .ptr_hit    (dec_hit),
        .idx_zero   (dec_zero)
    );

    pbus_pointer_regs #(.IDX_W(IDX_W), .SPTR_W(SPTR_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_start  (acc_start),
        .is_wr      (is_wr),
        .sel_serial (sel_serial),
        .mux_mode   (cfg_mux),
        .ptr_hit    (dec_hit),
        .idx_zero   (dec_zero),
        .wdata      (ad_in[IDX_W-1:0]),
        .ser_ptr    (ser_ptr),
        .dma_ptr    (dma_ptr),
        .ser_shl    (ser_shl)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_UNCONF;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_UNCONF: if (start && is_wr && !sel_serial) nxt = ST_CFGW;
            ST_CFGW:   if (!act) nxt = ST_IDLE;
            ST_IDLE:   if (start) nxt = is_wr ? ST_WRITE : ST_READ;
            ST_WRITE:  if (!act) nxt = ST_IDLE;
            ST_READ:   if (!act) nxt = ST_IDLE;
            default:   nxt = ST_UNCONF;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_wr_stb    <= 1'b0;
            reg_rd_stb    <= 1'b0;
            reg_cell_dma  <= 1'b0;
            reg_chan_a    <= 1'b0;
            reg_idx       <= '0;
            reg_wdata     <= '0;
            cfg_done      <= 1'b0;
            cfg_mux       <= 1'b0;
            cfg_wait_role <= 1'b0;
            dma_shl       <= 1'b0;
        end else begin
            reg_wr_stb <= acc_start && is_wr;
            reg_rd_stb <= acc_start && !is_wr;
            if (acc_start) begin
                reg_idx      <= dec_idx;
                reg_cell_dma <= !sel_serial;
                reg_chan_a   <= sel_serial && sel_chan_a;
                reg_wdata    <= is_wr ? ad_in[DATA_W-1:0] : '0;
            end
            if ((state == ST_UNCONF) && (nxt == ST_CFGW)) begin
                cfg_wait_role <= sel_chan_a;
                dma_shl       <= ad_in[0];
            end
            if ((state == ST_CFGW) && (nxt == ST_IDLE)) begin
                cfg_done <= 1'b1;
                cfg_mux  <= as_seen || !as_n;
            end
        end
    end

    assign ad_oe = (state == ST_READ);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ad_out[g*DATA_W +: DATA_W] = ad_oe ? reg_rd_data : '0;
    end

endmodule

// File: rtl/pbus_front_chk.sv
module pbus_front_chk #(
    parameter int AD_W   = 16,
    parameter int DATA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            reg_wr_stb,
    input logic            reg_rd_stb,
    input logic            reg_cell_dma,
    input logic            reg_chan_a,
    input logic            ad_oe,
    input logic [AD_W-1:0] ad_out,
    input logic            cfg_done,
    input logic            cfg_mux,
    input logic            cfg_wait_role
);

    AST_NO_STB_UNCONF: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> !(reg_wr_stb || reg_rd_stb)); // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (cfg_done && $stable(cfg_mux) && $stable(cfg_wait_role))); // R13

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |=> !reg_wr_stb); // R12

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_stb |=> !reg_rd_stb); // R14

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_stb, reg_rd_stb})); // R14

    AST_RD_OE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_stb |-> ad_oe); // R11

    AST_LANE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (ad_out[2*DATA_W-1:DATA_W] == ad_out[DATA_W-1:0])); // R11

    AST_DMA_NO_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr_stb || reg_rd_stb) && reg_cell_dma) |-> !reg_chan_a); // R10

endmodule

bind pbus_front pbus_front_chk #(.AD_W(AD_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_stb    (reg_wr_stb),
    .reg_rd_stb    (reg_rd_stb),
    .reg_cell_dma  (reg_cell_dma),
    .reg_chan_a    (reg_chan_a),
    .ad_oe         (ad_oe),
    .ad_out        (ad_out),
    .cfg_done      (cfg_done),
    .cfg_mux       (cfg_mux),
    .cfg_wait_role (cfg_wait_role)
);

// File: tb/pbus_front_test.sv
`timescale 1ns/1ps
module pbus_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        sel_serial = 1'b0, sel_chan_a = 1'b0;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [7:0]  reg_rd_data;
    logic        reg_wr_stb, reg_rd_stb, reg_cell_dma, reg_chan_a;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_wdata;
    logic        cfg_done, cfg_mux, cfg_wait_role;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // register stub: read byte encodes the target
    assign reg_rd_data = {reg_cell_dma, reg_chan_a, 1'b0, reg_idx};

    pbus_front uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .sel_serial(sel_serial), .sel_chan_a(sel_chan_a), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .reg_rd_data(reg_rd_data),
        .reg_wr_stb(reg_wr_stb), .reg_rd_stb(reg_rd_stb), .reg_cell_dma(reg_cell_dma),
        .reg_chan_a(reg_chan_a), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .cfg_done(cfg_done), .cfg_mux(cfg_mux), .cfg_wait_role(cfg_wait_role)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; as_n = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ad_in = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_addr(input int a);
        @(negedge clk);
        as_n = 1'b0; ad_in = 16'(a);
        @(negedge clk);
        as_n = 1'b1; ad_in = '0;
    endtask

    // one access; checks strobe, target, data and bus lanes
    task automatic xfer(input string req, input bit wr, input bit ser, input bit cha,
                        input int d, input int exp_idx);
        int exp_rd;
        @(negedge clk);
        cs_n = 1'b0; sel_serial = ser; sel_chan_a = cha;
        wr_n = !wr; rd_n = wr; ad_in = 16'(d);
        @(negedge clk);
        chk(req, "wr_stb", int'(reg_wr_stb), int'(wr));
        chk(req, "rd_stb", int'(reg_rd_stb), int'(!wr));
        chk(req, "idx", int'(reg_idx), exp_idx);
        chk(req, "cell", int'(reg_cell_dma), int'(!ser));
        chk(req, "chan", int'(reg_chan_a), int'(ser & cha));
        exp_rd = ((ser ? 0 : 1) << 7) | (int'(ser & cha) << 6) | exp_idx;
        if (wr) chk(req, "wdata", int'(reg_wdata), d & 8'hFF);
        else    chk(req, "ad_out", int'(ad_out), (exp_rd << 8) | exp_rd);
        chk(req, "ad_oe", int'(ad_oe), int'(!wr));
        @(negedge clk);
        chk(req, "stb_pulse", int'(reg_wr_stb | reg_rd_stb), 0);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ad_in = '0;
        @(negedge clk);
    endtask

    // access that must be ignored / configuration write
    task automatic raw_acc(input string req, input bit wr, input bit ser, input bit cha,
                           input int d, input bit as_now);
        @(negedge clk);
        cs_n = 1'b0; sel_serial = ser; sel_chan_a = cha;
        wr_n = !wr; rd_n = wr; ad_in = 16'(d); as_n = !as_now;
        @(negedge clk);
        as_n = 1'b1;
        chk(req, "no_stb", int'(reg_wr_stb | reg_rd_stb), 0);
        chk(req, "no_oe", int'(ad_oe), 0);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ad_in = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int shidx(input int a, input bit left);
        return left ? ((a >> 1) & 31) : (a & 31);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R13", "reset cfg_done", int'(cfg_done), 0);
        chk("R13", "reset oe", int'(ad_oe), 0);

        // R1: improper first accesses are ignored
        raw_acc("R1", 1'b0, 1'b0, 1'b0, 0, 1'b0);
        chk("R1", "cfg after read", int'(cfg_done), 0);
        raw_acc("R1", 1'b1, 1'b1, 1'b1, 3, 1'b0);
        chk("R1", "cfg after serial wr", int'(cfg_done), 0);

        // R2/R3/R4: non-multiplexed configuration, wait role
        raw_acc("R2", 1'b1, 1'b0, 1'b1, 0, 1'b0);
        chk("R2", "cfg_done", int'(cfg_done), 1);
        chk("R3", "cfg_mux", int'(cfg_mux), 0);
        chk("R4", "wait_role", int'(cfg_wait_role), 1);

        // R7: serial pointer sweep, both channels
        for (int p = 1; p < 16; p++) begin
            xfer("R7", 1'b1, 1'b1, p[0], p, 0);
            xfer("R7", 1'b0, 1'b1, p[0], 0, p);
            xfer("R7", 1'b0, 1'b1, p[0], 0, 0);
        end

        // R8: DMA pointer sweep in non-multiplexed mode
        for (int p = 1; p < 32; p++) begin
            xfer("R8", 1'b1, 1'b0, 1'b1, p, 0);
            xfer("R8", 1'b1, 1'b0, 1'b0, 8'hA5, p);
            xfer("R8", 1'b0, 1'b0, 1'b1, 0, 0);
        end

        // R13: configuration is not re-writable
        xfer("R13", 1'b1, 1'b0, 1'b0, 8'h20, 0);
        chk("R13", "mux kept", int'(cfg_mux), 0);
        chk("R13", "role kept", int'(cfg_wait_role), 1);

        // R13/R3/R4/R5: reset, strobe with chip enable high, then configure
        do_reset();
        chk("R13", "cfg cleared", int'(cfg_done), 0);
        set_addr(16'h0033);
        raw_acc("R3", 1'b1, 1'b0, 1'b0, 1, 1'b0);
        chk("R3", "cfg_mux", int'(cfg_mux), 1);
        chk("R4", "ready role", int'(cfg_wait_role), 0);

        // R5: DMA shift-left sweep
        for (int a = 2; a < 64; a++) begin
            if (shidx(a, 1'b1) != 0) begin
                set_addr(a);
                xfer("R5", 1'b0, 1'b0, a[0], 0, shidx(a, 1'b1));
            end
        end

        // R6: serial shift right after reset
        for (int a = 1; a < 32; a++) begin
            set_addr(a);
            xfer("R6", 1'b0, 1'b1, a[1], 0, shidx(a, 1'b0));
        end
        // R6: switch to left, keep with 11, back to right with 10
        set_addr(0);
        xfer("R6", 1'b1, 1'b1, 1'b1, 8'h01, 0);
        for (int a = 2; a < 64; a += 5) begin
            set_addr(a);
            xfer("R6", 1'b0, 1'b1, 1'b0, 0, shidx(a, 1'b1));
        end
        set_addr(0);
        xfer("R6", 1'b1, 1'b1, 1'b1, 8'h03, 0);
        set_addr(22);
        xfer("R6", 1'b0, 1'b1, 1'b1, 0, 11);
        set_addr(0);
        xfer("R6", 1'b1, 1'b1, 1'b1, 8'h02, 0);
        set_addr(22);
        xfer("R6", 1'b0, 1'b1, 1'b1, 0, 22);

        // R9: serial pointer ignored in multiplexed mode
        set_addr(0);
        xfer("R9", 1'b1, 1'b1, 1'b0, 8'h0C, 0);
        set_addr(0);
        xfer("R9", 1'b0, 1'b1, 1'b0, 0, 0);
        set_addr(5);
        xfer("R9", 1'b0, 1'b1, 1'b0, 0, 5);

        // R8: DMA pointer in multiplexed mode
        set_addr(0);
        xfer("R8", 1'b1, 1'b0, 1'b0, 7, 0);
        set_addr(0);
        xfer("R8", 1'b0, 1'b0, 1'b0, 0, 7);
        set_addr(0);
        xfer("R8", 1'b0, 1'b0, 1'b0, 0, 0);
        set_addr(0);
        xfer("R8", 1'b1, 1'b0, 1'b0, 9, 0);
        set_addr(4);
        xfer("R8", 1'b0, 1'b0, 1'b0, 0, 2);
        set_addr(0);
        xfer("R8", 1'b1, 1'b0, 1'b0, 8'h55, 9);
        set_addr(0);
        xfer("R8", 1'b0, 1'b0, 1'b0, 0, 0);

        // R3: strobe only in the cycle the configuration write starts
        do_reset();
        raw_acc("R3", 1'b1, 1'b0, 1'b1, 0, 1'b1);
        chk("R3", "same-cycle strobe mux", int'(cfg_mux), 1);
        set_addr(9);
        xfer("R3", 1'b0, 1'b0, 1'b0, 0, 9);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule